// File: doc/BRIEF.md
# Configuration Store Command Controller

This block sits between a small non-volatile configuration store and the byte registers that software sees. A handful of RAM mirror registers shadow the first bytes of the store, and the rest of the store holds user bytes. Software moves data by loading a store address and a data byte into two registers and then writing a command code into a third. One code writes one byte into the store, one fetches one byte into the data register, and one copies every mirror register into its slot in the store. While a command runs, a busy bit in the status register is high.

Commands are only taken while software holds a refresh-disable bit in the control register. When that bit goes from set to clear, the controller reloads every mirror register from the store, one byte per cycle. The store is a behavioural array. Each byte it programs costs a configurable number of clock cycles, so a full update costs that delay once for every mirror byte. The store is cleared by reset so that simulations start from known values.

Top module: `eeCmdTop`

## Requirements
- R1: After reset, every register read returns 0x00: status (0x0E), control (0x10), store address (0x3D), store data (0x3E) and every mirror register (0xC0 to 0xC0+MIRROR_CNT-1). The busy bit (status bit 2) is 0.
- R2: A command written to 0x3F while control bit 3 (refresh-disable) is 0 is ignored. Busy stays 0 and the store is unchanged.
- R3: A command written while busy is 1 is ignored. The running command finishes on its original schedule, and the ignored command leaves no trace in the store.
- R4: Code 0x21 writes the store-data register into the store byte selected by the store-address register. Busy is high for exactly WR_DELAY cycles.
- R5: Code 0x22 loads the addressed store byte into the store-data register. Busy is high for exactly 1 cycle.
- R6: Code 0x11 copies mirror register i (bus address 0xC0+i) to store byte 0xC0+i for every i below MIRROR_CNT. Busy is high for MIRROR_CNT*WR_DELAY cycles and user bytes are untouched. The mirror registers can be written and read directly on the bus.
- R7: A control write that clears bit 3 while it was set reloads every mirror register from its store byte, with busy high for MIRROR_CNT cycles. Setting bit 3, or writing it 0 while it is already 0, starts no reload.
- R8: A command code other than 0x11, 0x21 or 0x22 is ignored.
- R9: Status bit 2 mirrors busy and the other status bits read 0. The command register reads 0x00 and the control register reads back as written.
- R10: The store spans 0xC0 to 0xC0+MIRROR_CNT+USER_CNT-1, which is 0xC0 to 0xEA by default. A write to an address outside that span changes no byte, and a read from such an address returns 0x00. Both still take their normal busy time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 8 | Register write address |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 8 | Register read address |
| regRdData | output | 8 | Combinational read data for regRdAddr |

## Verification
The bench writes and reads back every store address under a distinct arithmetic pattern. An address decode that is off by one would alias two bytes or drop the last user byte. It also hits the addresses just outside the span from both sides, where a missing range check would corrupt a real byte or return stale data. The busy time of every command kind is measured and compared against the parameter arithmetic. A controller that issued a second command while one was running would stretch that time or overwrite mirror slots. The bench also covers the refresh edge: a clearing write must reload the mirrors, while a set or a repeated clear must not, so a design that detected level instead of transition would show a spurious busy.

// File: rtl/eeCmdPkg.sv
package eeCmdPkg;
  localparam logic [7:0] ADDR_STATUS = 8'h0E;
  localparam logic [7:0] ADDR_CTRL   = 8'h10;
  localparam logic [7:0] ADDR_EEADDR = 8'h3D;
  localparam logic [7:0] ADDR_EEDATA = 8'h3E;
  localparam logic [7:0] ADDR_EECMD  = 8'h3F;
  localparam logic [7:0] STORE_BASE  = 8'hC0;

  localparam int BUSY_BIT   = 2;
  localparam int REFDIS_BIT = 3;

  localparam logic [7:0] CMD_UPDATE_ALL = 8'h11;
  localparam logic [7:0] CMD_WRITE_ONE  = 8'h21;
  localparam logic [7:0] CMD_READ_ONE   = 8'h22;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_UPD,
    ST_REF
  } ctrlState_e;

  typedef struct packed {
    logic wrSingle;  // store[eeAddr] <= eeData
    logic wrMirror;  // store[idx]    <= mirror[idx]
    logic ldData;    // eeData        <= store[eeAddr]
    logic ldMirror;  // mirror[idx]   <= store[idx]
  } eeStrobe_t;
endpackage

// File: rtl/eeCmdCtrl.sv
module eeCmdCtrl
  import eeCmdPkg::*;
#(
  parameter int WR_DELAY   = 10,
  parameter int MIRROR_CNT = 11,
  parameter int IDX_W      = $clog2(MIRROR_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStrobe,
  input  logic [7:0]       cmdCode,
  input  logic             refreshDis,
  input  logic             refreshFall,
  output eeStrobe_t        strobe,
  output logic [IDX_W-1:0] idx,
  output logic             busy
);
  localparam int CNT_W = $clog2(WR_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(WR_DELAY - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(MIRROR_CNT - 1);

  ctrlState_e state;
  logic [CNT_W-1:0] cnt;
  logic refPend;

  always_comb begin
    busy   = (state != ST_IDLE);
    strobe = '0;
    unique case (state)
      ST_WR:   strobe.wrSingle = (cnt == '0);
      ST_UPD:  strobe.wrMirror = (cnt == '0);
      ST_RD:   strobe.ldData   = 1'b1;
      ST_REF:  strobe.ldMirror = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      refPend <= 1'b0;
    end else begin
      if (refreshFall && state != ST_IDLE) refPend <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (refPend || refreshFall) begin
            state   <= ST_REF;
            idx     <= '0;
            refPend <= 1'b0;
          end else if (cmdStrobe && refreshDis) begin
            case (cmdCode)
              CMD_WRITE_ONE: begin
                state <= ST_WR;
                cnt   <= CNT_RELOAD;
              end
              CMD_READ_ONE: state <= ST_RD;
              CMD_UPDATE_ALL: begin
                state <= ST_UPD;
                cnt   <= CNT_RELOAD;
                idx   <= '0;
              end
              default: ;
            endcase
          end
        end
        ST_WR: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_RD: state <= ST_IDLE;
        ST_UPD: begin
          if (cnt == '0) begin
            cnt <= CNT_RELOAD;
            if (idx == IDX_LAST) state <= ST_IDLE;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REF: begin
          if (idx == IDX_LAST) state <= ST_IDLE;
          else idx <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: length of the current busy run and the kind of operation
  localparam int LEN_W = $clog2(MIRROR_CNT * WR_DELAY + 2);
  logic [LEN_W-1:0] busyLen;
  ctrlState_e lastOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLen <= '0;
      lastOp  <= ST_IDLE;
    end else begin
      busyLen <= busy ? busyLen + 1'b1 : '0;
      if (busy) lastOp <= state;
    end
  end

  assert_ignore_when_enabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && !refreshDis && !busy && !refPend && !refreshFall) |=> !busy);

  assert_ignore_when_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && state == ST_WR && cnt != '0) |=> (state == ST_WR));

  assert_write_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && lastOp == ST_WR) |-> (busyLen == LEN_W'(WR_DELAY)));

  assert_read_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && lastOp == ST_RD) |-> (busyLen == LEN_W'(1)));

  assert_update_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && lastOp == ST_UPD) |-> (busyLen == LEN_W'(MIRROR_CNT * WR_DELAY)));

  assert_one_store_port_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSingle, strobe.wrMirror, strobe.ldData, strobe.ldMirror}));

  assert_refresh_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && lastOp == ST_REF) |-> (busyLen == LEN_W'(MIRROR_CNT)));
endmodule

// File: rtl/eeCmdData.sv
module eeCmdData
  import eeCmdPkg::*;
#(
  parameter int MIRROR_CNT = 11,
  parameter int USER_CNT   = 32,
  parameter int IDX_W      = $clog2(MIRROR_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regWrAddr,
  input  logic [7:0]       regWrData,
  input  logic [7:0]       regRdAddr,
  output logic [7:0]       regRdData,
  input  eeStrobe_t        strobe,
  input  logic [IDX_W-1:0] idx,
  input  logic             busy,
  output logic             cmdStrobe,
  output logic [7:0]       cmdCode,
  output logic             refreshDis,
  output logic             refreshFall
);
  localparam int STORE_CNT = MIRROR_CNT + USER_CNT;
  localparam int SIDX_W    = $clog2(STORE_CNT);
  localparam logic [8:0] STORE_END9  = 9'(STORE_CNT);
  localparam logic [8:0] MIRROR_END9 = 9'(MIRROR_CNT);

  logic [7:0] ctrlReg, eeAddr, eeData;
  logic [7:0] mirror [MIRROR_CNT];
  logic [7:0] store  [STORE_CNT];

  // Store address decode
  logic [8:0] eeOff;
  logic eeInRange;
  logic [7:0] storeRdByte;
  assign eeOff       = {1'b0, eeAddr} - {1'b0, STORE_BASE};
  assign eeInRange   = (eeAddr >= STORE_BASE) && (eeOff < STORE_END9);
  assign storeRdByte = eeInRange ? store[eeOff[SIDX_W-1:0]] : 8'h00;

  // Bus decode
  logic [8:0] wrOff, rdOff;
  logic wrMirrorHit, rdMirrorHit;
  assign wrOff       = {1'b0, regWrAddr} - {1'b0, STORE_BASE};
  assign rdOff       = {1'b0, regRdAddr} - {1'b0, STORE_BASE};
  assign wrMirrorHit = regWrEn && (regWrAddr >= STORE_BASE) && (wrOff < MIRROR_END9);
  assign rdMirrorHit = (regRdAddr >= STORE_BASE) && (rdOff < MIRROR_END9);

  assign cmdStrobe   = regWrEn && (regWrAddr == ADDR_EECMD);
  assign cmdCode     = regWrData;
  assign refreshDis  = ctrlReg[REFDIS_BIT];
  assign refreshFall = regWrEn && (regWrAddr == ADDR_CTRL) &&
                       ctrlReg[REFDIS_BIT] && !regWrData[REFDIS_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      eeAddr  <= '0;
      eeData  <= '0;
    end else begin
      if (regWrEn && regWrAddr == ADDR_CTRL)   ctrlReg <= regWrData;
      if (regWrEn && regWrAddr == ADDR_EEADDR) eeAddr  <= regWrData;
      if (strobe.ldData)                       eeData  <= storeRdByte;
      else if (regWrEn && regWrAddr == ADDR_EEDATA) eeData <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MIRROR_CNT; i++) mirror[i] <= '0;
    end else if (strobe.ldMirror) begin
      mirror[idx] <= store[SIDX_W'(idx)];
    end else if (wrMirrorHit) begin
      mirror[wrOff[IDX_W-1:0]] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STORE_CNT; i++) store[i] <= '0;
    end else if (strobe.wrSingle && eeInRange) begin
      store[eeOff[SIDX_W-1:0]] <= eeData;
    end else if (strobe.wrMirror) begin
      store[SIDX_W'(idx)] <= mirror[idx];
    end
  end

  always_comb begin
    regRdData = 8'h00;
    if (rdMirrorHit) begin
      regRdData = mirror[rdOff[IDX_W-1:0]];
    end else begin
      case (regRdAddr)
        ADDR_STATUS: regRdData[BUSY_BIT] = busy;
        ADDR_CTRL:   regRdData = ctrlReg;
        ADDR_EEADDR: regRdData = eeAddr;
        ADDR_EEDATA: regRdData = eeData;
        default:     regRdData = 8'h00;
      endcase
    end
  end

  assert_read_fetch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldData && eeInRange) |=> (eeData == $past(storeRdByte)));

  assert_oob_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldData && !eeInRange) |=> (eeData == 8'h00));

  assert_status_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdAddr == ADDR_STATUS) |-> (regRdData[BUSY_BIT] == busy && regRdData[7:3] == 5'd0));
endmodule

// File: rtl/eeCmdTop.sv
module eeCmdTop
  import eeCmdPkg::*;
#(
  parameter int WR_DELAY   = 10,
  parameter int MIRROR_CNT = 11,
  parameter int USER_CNT   = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrAddr,
  input  logic [7:0] regWrData,
  input  logic [7:0] regRdAddr,
  output logic [7:0] regRdData
);
  localparam int IDX_W = $clog2(MIRROR_CNT);

  eeStrobe_t strobe;
  logic [IDX_W-1:0] idx;
  logic busy, cmdStrobe, refreshDis, refreshFall;
  logic [7:0] cmdCode;

  eeCmdCtrl #(
    .WR_DELAY(WR_DELAY), .MIRROR_CNT(MIRROR_CNT), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode),
    .refreshDis(refreshDis), .refreshFall(refreshFall),
    .strobe(strobe), .idx(idx), .busy(busy)
  );

  eeCmdData #(
    .MIRROR_CNT(MIRROR_CNT), .USER_CNT(USER_CNT), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .strobe(strobe), .idx(idx), .busy(busy), .cmdStrobe(cmdStrobe),
    .cmdCode(cmdCode), .refreshDis(refreshDis), .refreshFall(refreshFall)
  );
endmodule

// File: tb/eeCmdTop_tb.sv
`timescale 1ns/1ps
module eeCmdTop_tb;
  localparam int D = 4;
  localparam int M = 11;
  localparam int U = 32;
  localparam int BASE = 8'hC0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrAddr = '0, regWrData = '0, regRdAddr = '0;
  logic [7:0] regRdData;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  eeCmdTop #(.WR_DELAY(D), .MIRROR_CNT(M), .USER_CNT(U)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] mpat(input int i);
    return 8'((i * 19 + 8'h80) & 255);
  endfunction
  function automatic logic [7:0] rpat(input int i);
    return 8'((i * 5 + 8'h41) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    regRdAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic busyLen(output int n);
    logic [7:0] s;
    n = 0;
    rd(8'h0E, s);
    while (s[2] && n < 5000) begin
      n++;
      @(negedge clk);
      rd(8'h0E, s);
    end
  endtask

  task automatic cmd(input logic [7:0] code, input int expLen, input string req);
    int n;
    wr(8'h3F, code);
    busyLen(n);
    chk(req, n, expLen, "busy cycles");
  endtask

  task automatic storeWrite(input int a, input logic [7:0] d, input string req);
    wr(8'h3D, 8'(a));
    wr(8'h3E, d);
    cmd(8'h21, D, req);
  endtask

  task automatic storeRead(input int a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    wr(8'h3D, 8'(a));
    cmd(8'h22, 1, req);
    rd(8'h3E, v);
    chk(req, v, exp, "fetched byte");
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL all watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h0E, v); chk("R1", v, 0, "status");
    rd(8'h10, v); chk("R1", v, 0, "control");
    rd(8'h3D, v); chk("R1", v, 0, "store address");
    rd(8'h3E, v); chk("R1", v, 0, "store data");
    for (int i = 0; i < M; i++) begin
      rd(8'(BASE + i), v); chk("R1", v, 0, "mirror");
    end

    // R2: command ignored while refresh is enabled
    wr(8'h3D, 8'hCB);
    wr(8'h3E, 8'h5A);
    wr(8'h3F, 8'h21);
    rd(8'h0E, v); chk("R2", v, 0, "status after ignored write cmd");
    wr(8'h10, 8'h08);
    rd(8'h0E, v); chk("R7", v, 0, "no reload on setting bit3");
    rd(8'h10, v); chk("R9", v, 8'h08, "control readback");
    storeRead(8'hCB, 8'h00, "R2");

    // R4/R5: sweep every store address
    for (int a = BASE; a < BASE + M + U; a++) storeWrite(a, pat(a), "R4");
    for (int a = BASE; a < BASE + M + U; a++) storeRead(a, pat(a), "R5");

    // R10: addresses just outside the span and far outside
    storeWrite(8'hBF, 8'hFF, "R10");
    storeWrite(8'hEB, 8'hFF, "R10");
    storeWrite(8'hFF, 8'hFF, "R10");
    storeWrite(8'h00, 8'hFF, "R10");
    storeRead(8'hBF, 8'h00, "R10");
    storeRead(8'hEB, 8'h00, "R10");
    storeRead(8'hFF, 8'h00, "R10");
    storeRead(BASE + M + U - 1, pat(BASE + M + U - 1), "R10");
    storeRead(BASE, pat(BASE), "R10");

    // R9: register map during a busy write; R3: command while busy
    wr(8'h3D, 8'hCB);
    wr(8'h3E, 8'h77);
    wr(8'h3F, 8'h21);
    rd(8'h0E, v); chk("R9", v, 8'h04, "status while busy");
    rd(8'h3F, v); chk("R9", v, 8'h00, "command reg read");
    wr(8'h3F, 8'h11);
    busyLen(n);
    chk("R3", n, D - 2, "remaining busy after ignored cmd");
    storeRead(8'hCB, 8'h77, "R4");
    storeRead(BASE, pat(BASE), "R3");

    // R8: unknown codes
    wr(8'h3F, 8'h33);
    rd(8'h0E, v); chk("R8", v, 0, "status after code 0x33");
    wr(8'h3F, 8'h00);
    rd(8'h0E, v); chk("R8", v, 0, "status after code 0x00");
    rd(8'h3E, v); chk("R8", v, pat(BASE), "data reg unchanged");

    // R6: update-all
    for (int i = 0; i < M; i++) wr(8'(BASE + i), mpat(i));
    for (int i = 0; i < M; i++) begin
      rd(8'(BASE + i), v); chk("R6", v, mpat(i), "mirror readback");
    end
    cmd(8'h11, M * D, "R6");
    for (int i = 0; i < M; i++) storeRead(BASE + i, mpat(i), "R6");
    storeRead(8'hCB, 8'h77, "R6");

    // R7: refresh on clearing bit3
    for (int i = 0; i < M; i++) storeWrite(BASE + i, rpat(i), "R4");
    rd(8'(BASE), v); chk("R7", v, mpat(0), "mirror before reload");
    wr(8'h10, 8'h00);
    busyLen(n);
    chk("R7", n, M, "reload busy cycles");
    for (int i = 0; i < M; i++) begin
      rd(8'(BASE + i), v); chk("R7", v, rpat(i), "mirror after reload");
    end
    wr(8'h10, 8'h00);
    rd(8'h0E, v); chk("R7", v, 0, "no reload on repeated clear");
    wr(8'h3F, 8'h22);
    rd(8'h0E, v); chk("R2", v, 0, "read cmd ignored when enabled");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule